// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in four parallel lanes. Each lane keeps the middle sixteen bits of its product and rounds half up. A 3-bit mode picks the operands for each lane and where each lane result lands in the 64-bit output. Pixels can come from the low four bytes of `op_a`, or from the upper or lower byte of each 16-bit field of `op_a`. Coefficients can come from each 16-bit lane of `op_b`, or from one halfword of `op_b` shared by all lanes. A two-lane form writes its 16-bit results into the 32-bit fields of the output, each shifted up by seven bits.

All modes share one array of four lane multipliers. An operand selector sits in front of the array and a result placer sits behind it. An optional output register, on by default, gives the block one cycle of latency.

Top module: `pmul8x16`

## Requirements
- R1: The lane result is bits [23:8] of the 24-bit two's-complement product (unsigned pixel times signed coefficient), plus one when product bit 7 is set.
- R2: The rounding increment wraps within 16 bits and never saturates. A pixel of 1 times a coefficient of 0xFFFF gives 0x0000, and a pixel of 255 times 0xFFFF gives 0xFFFF.
- R3: In mode 0 (LANE), byte i of `op_a[31:0]` multiplies 16-bit lane i of `op_b`, and the result goes to output lane i (bits 16i+15..16i).
- R4: In mode 1 (SHARED_HI) and mode 2 (SHARED_LO), byte i of `op_a[31:0]` multiplies `op_b[31:16]` (mode 1) or `op_b[15:0]` (mode 2). The result goes to output lane i.
- R5: In mode 3 (BYTE_HI) and mode 4 (BYTE_LO), lane i multiplies `op_a[16i+15:16i+8]` (mode 3) or `op_a[16i+7:16i]` (mode 4) by 16-bit lane i of `op_b`. The result goes to output lane i.
- R6: In mode 5 (WIDE_HI) and mode 6 (WIDE_LO), only lanes 0 and 1 are computed, with the byte selection of modes 3 and 4. Each result sits at bits 32i+22..32i+7, and all other output bits are zero.
- R7: Mode 7 (NONE) drives the whole output to zero.
- R8: `op_a[63:32]` has no effect in modes 0, 1, 2, 5 and 6. `op_b[63:32]` has no effect in modes 1, 2, 5 and 6.
- R9: With the output register enabled, the result appears one clock edge after its inputs. An active-low asynchronous reset clears the output to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 3 | Lane selection mode, encoded as in R3 to R7 |
| op_a | input | 64 | Pixel operand (unsigned bytes) |
| op_b | input | 64 | Coefficient operand (signed halfwords) |
| res | output | 64 | Lane results |

## Verification
The hardest case to reach is the rounding increment that wraps, because it needs a product whose bits [23:7] are all ones. That happens only for small pixels times negative coefficients close to zero. The bench aims at it with a shared coefficient of 0xFFFF and pixels of 1, 2, 128 and 255. The wide modes are checked for both the shifted placement and the zero gaps between fields, and random sweeps over all eight modes are compared against an arithmetic model built from the requirements.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

    typedef enum logic [2:0] {
        MD_LANE    = 3'd0,
        MD_SHR_HI  = 3'd1,
        MD_SHR_LO  = 3'd2,
        MD_BYTE_HI = 3'd3,
        MD_BYTE_LO = 3'd4,
        MD_WIDE_HI = 3'd5,
        MD_WIDE_LO = 3'd6,
        MD_NONE    = 3'd7
    } pm_mode_e;

endpackage

// File: rtl/pm_operand_sel.sv
module pm_operand_sel
    import pmul_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int LANES  = 4
) (
    input  pm_mode_e                        mode,
    input  logic [LANES*COEF_W-1:0]         op_a,
    input  logic [LANES*COEF_W-1:0]         op_b,
    output logic [LANES-1:0][PIX_W-1:0]     pix,
    output logic [LANES-1:0][COEF_W-1:0]    coef
);
    localparam int WIDE_LANES = LANES / 2;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            pix[i]  = '0;
            coef[i] = '0;
            unique case (mode)
                MD_LANE: begin
                    pix[i]  = op_a[i*PIX_W +: PIX_W];
                    coef[i] = op_b[i*COEF_W +: COEF_W];
                end
                MD_SHR_HI: begin
                    pix[i]  = op_a[i*PIX_W +: PIX_W];
                    coef[i] = op_b[COEF_W +: COEF_W];
                end
                MD_SHR_LO: begin
                    pix[i]  = op_a[i*PIX_W +: PIX_W];
                    coef[i] = op_b[0 +: COEF_W];
                end
                MD_BYTE_HI: begin
                    pix[i]  = op_a[i*COEF_W + PIX_W +: PIX_W];
                    coef[i] = op_b[i*COEF_W +: COEF_W];
                end
                MD_BYTE_LO: begin
                    pix[i]  = op_a[i*COEF_W +: PIX_W];
                    coef[i] = op_b[i*COEF_W +: COEF_W];
                end
                MD_WIDE_HI: begin
                    if (i < WIDE_LANES) begin
                        pix[i]  = op_a[i*COEF_W + PIX_W +: PIX_W];
                        coef[i] = op_b[i*COEF_W +: COEF_W];
                    end
                end
                MD_WIDE_LO: begin
                    if (i < WIDE_LANES) begin
                        pix[i]  = op_a[i*COEF_W +: PIX_W];
                        coef[i] = op_b[i*COEF_W +: COEF_W];
                    end
                end
                MD_NONE: begin
                    pix[i]  = '0;
                    coef[i] = '0;
                end
                default: begin
                    pix[i]  = '0;
                    coef[i] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pm_lane_mul.sv
module pm_lane_mul #(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16
) (
    input  logic [PIX_W-1:0]  pix,
    input  logic [COEF_W-1:0] coef,
    output logic [COEF_W-1:0] lane_res
);
    localparam int PROD_W = PIX_W + COEF_W + 1;

    logic signed [PROD_W-1:0] prod;
    logic [COEF_W-1:0]        kept;
    logic                     half_bit;

    always_comb begin
        prod     = $signed({1'b0, pix}) * $signed(coef);
        kept     = prod[PIX_W+COEF_W-1:PIX_W];
        half_bit = prod[PIX_W-1];
        lane_res = kept + {{(COEF_W-1){1'b0}}, half_bit};
    end

endmodule

// File: rtl/pm_result_place.sv
module pm_result_place
    import pmul_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int COEF_W = 16,
    parameter int LANES  = 4
) (
    input  pm_mode_e                        mode,
    input  logic [LANES-1:0][COEF_W-1:0]    lane_res,
    output logic [LANES*COEF_W-1:0]         placed
);
    localparam int WIDE_LANES = LANES / 2;
    localparam int FIELD_W    = 2 * COEF_W;
    localparam int WIDE_OFS   = PIX_W - 1;

    always_comb begin
        placed = '0;
        unique case (mode)
            MD_LANE, MD_SHR_HI, MD_SHR_LO, MD_BYTE_HI, MD_BYTE_LO: begin
                for (int i = 0; i < LANES; i++)
                    placed[i*COEF_W +: COEF_W] = lane_res[i];
            end
            MD_WIDE_HI, MD_WIDE_LO: begin
                for (int i = 0; i < WIDE_LANES; i++)
                    placed[i*FIELD_W + WIDE_OFS +: COEF_W] = lane_res[i];
            end
            MD_NONE: placed = '0;
            default: placed = '0;
        endcase
    end

endmodule

// File: rtl/pmul8x16.sv
module pmul8x16
    import pmul_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 16,
    parameter int LANES   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2:0]              mode,
    input  logic [LANES*COEF_W-1:0] op_a,
    input  logic [LANES*COEF_W-1:0] op_b,
    output logic [LANES*COEF_W-1:0] res
);
    localparam int OP_W = LANES * COEF_W;

    pm_mode_e                       mode_e;
    logic [LANES-1:0][PIX_W-1:0]    pix;
    logic [LANES-1:0][COEF_W-1:0]   coef;
    logic [LANES-1:0][COEF_W-1:0]   lane_res;
    logic [OP_W-1:0]                placed;

    assign mode_e = pm_mode_e'(mode);

    pm_operand_sel #(.PIX_W(PIX_W), .COEF_W(COEF_W), .LANES(LANES)) u_sel (
        .mode (mode_e),
        .op_a (op_a),
        .op_b (op_b),
        .pix  (pix),
        .coef (coef)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pm_lane_mul #(.PIX_W(PIX_W), .COEF_W(COEF_W)) u_mul (
            .pix      (pix[g]),
            .coef     (coef[g]),
            .lane_res (lane_res[g])
        );
    end

    pm_result_place #(.PIX_W(PIX_W), .COEF_W(COEF_W), .LANES(LANES)) u_place (
        .mode     (mode_e),
        .lane_res (lane_res),
        .placed   (placed)
    );

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) res <= '0;
            else        res <= placed;
        end
    end else begin : g_comb
        assign res = placed;
    end

endmodule

// File: rtl/pm_chk.sv
module pm_chk #(
    parameter int PIX_W   = 8,
    parameter int COEF_W  = 16,
    parameter int LANES   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [2:0]              mode,
    input logic [LANES*COEF_W-1:0] op_a,
    input logic [LANES*COEF_W-1:0] op_b,
    input logic [LANES*COEF_W-1:0] res
);
    localparam int OP_W = LANES * COEF_W;

    logic [2:0]      mode_q;
    logic [OP_W-1:0] a_q, b_q;
    logic [2:0]      mode_v;
    logic [OP_W-1:0] a_v, b_v;
    logic [OP_W-1:0] wide_gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 3'd7;
            a_q    <= '0;
            b_q    <= '0;
        end else begin
            mode_q <= mode;
            a_q    <= op_a;
            b_q    <= op_b;
        end
    end

    assign mode_v = REG_OUT ? mode_q : mode;
    assign a_v    = REG_OUT ? a_q : op_a;
    assign b_v    = REG_OUT ? b_q : op_b;

    always_comb begin
        wide_gap = '1;
        for (int i = 0; i < LANES / 2; i++)
            wide_gap[i*2*COEF_W + PIX_W - 1 +: COEF_W] = '0;
    end

    // R6
    wide_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v == 3'd5 || mode_v == 3'd6) |-> ((res & wide_gap) == '0));

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v == 3'd7) |-> (res == '0));

    // R1
    zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v == 3'd0 && b_v[COEF_W-1:0] == '0) |-> (res[COEF_W-1:0] == '0));

    // R5
    unit_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_v == 3'd3 && b_v[COEF_W-1:0] == (COEF_W'(1) << PIX_W))
        |-> (res[COEF_W-1:0] == {{(COEF_W-PIX_W){1'b0}}, a_v[PIX_W +: PIX_W]}));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        (REG_OUT && !rst_n) |=> (res == '0));

endmodule

bind pmul8x16 pm_chk #(
    .PIX_W(PIX_W), .COEF_W(COEF_W), .LANES(LANES), .REG_OUT(REG_OUT)
) u_pm_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .op_a  (op_a),
    .op_b  (op_b),
    .res   (res)
);

// File: tb/test_pmul8x16.sv
module test_pmul8x16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd7;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [63:0] res;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    pmul8x16 i_pmul8x16 (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .op_a(op_a), .op_b(op_b), .res(res)
    );

    // fields: mode, op_a, op_b, expected
    localparam logic [194:0] VEC [8] = '{
        {3'd0, 64'hFFFF_FFFF_0403_0201, 64'hFF00_0080_0200_0100, 64'hFFFC_0002_0004_0001},
        {3'd1, 64'h0000_0000_FF80_0201, 64'h1234_5678_0100_7777, 64'h00FF_0080_0002_0001},
        {3'd2, 64'h0000_0000_FF80_0201, 64'h1234_5678_0100_FFFF, 64'hFFFF_0000_0000_0000},
        {3'd3, 64'h1011_2033_3055_4077, 64'h0100_0100_0100_0100, 64'h0010_0020_0030_0040},
        {3'd4, 64'h1011_2033_3055_4077, 64'h0100_0100_0100_0100, 64'h0011_0033_0055_0077},
        {3'd5, 64'hAAAA_AAAA_0300_0200, 64'hBBBB_BBBB_0100_0080, 64'h0000_0180_0000_0080},
        {3'd6, 64'h0000_0000_0005_0006, 64'hFFFF_FFFF_0100_FF00, 64'h0000_0280_007F_FD00},
        {3'd7, 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h0000_0000_0000_0000}
    };

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0:       return "R3";
            3'd1, 3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5, 3'd6: return "R6";
            default:    return "R7";
        endcase
    endfunction

    function automatic logic [15:0] ref_lane(input logic [7:0] p, input logic [15:0] c);
        int prod;
        int r;
        prod = int'(p) * int'($signed(c));
        r = (prod >>> 8) + ((prod >>> 7) & 1);
        return r[15:0];
    endfunction

    function automatic logic [63:0] ref_model(input logic [2:0] m, input logic [63:0] a,
                                              input logic [63:0] b);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            case (m)
                3'd0: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[16*i +: 16]);
                3'd1: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[31:16]);
                3'd2: r[16*i +: 16] = ref_lane(a[8*i +: 8], b[15:0]);
                3'd3: r[16*i +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd4: r[16*i +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                3'd5: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i+8 +: 8], b[16*i +: 16]);
                3'd6: if (i < 2) r[32*i+7 +: 16] = ref_lane(a[16*i +: 8], b[16*i +: 16]);
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] exp);
        total++;
        if (res !== exp) begin
            bad++;
            $display("FAIL %s: res=%h expected=%h (mode=%0d a=%h b=%h)",
                     req, res, exp, mode, op_a, op_b);
        end
    endtask

    task automatic apply(input logic [2:0] m, input logic [63:0] a, input logic [63:0] b);
        mode = m; op_a = a; op_b = b;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end");
        finish_run();
    end

    initial begin
        logic [63:0] prev;
        logic [63:0] a2;
        logic [63:0] b2;
        // R9: output cleared while in reset
        repeat (3) @(negedge clk);
        check("R9", 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk covers R3..R7 and R2 (row 2 wraps)
        for (int k = 0; k < 8; k++) begin
            apply(VEC[k][194:192], VEC[k][191:128], VEC[k][127:64]);
            check(req_of(VEC[k][194:192]), VEC[k][63:0]);
        end

        // R9: one-cycle latency, old value held before the edge
        apply(3'd3, 64'h1011_2033_3055_4077, 64'h0100_0100_0100_0100);
        prev = res;
        mode = 3'd0; op_a = 64'h0403_0201; op_b = 64'hFF00_0080_0200_0100;
        #5;
        check("R9", prev);
        @(posedge clk); @(negedge clk);
        check("R9", 64'hFFFC_0002_0004_0001);

        // R2: wrap to zero and to 0xFFFF with a shared coefficient of -1
        apply(3'd2, 64'h0000_0000_FF80_0201, 64'h0000_0000_0000_FFFF);
        check("R2", 64'hFFFF_0000_0000_0000);

        // R1: largest magnitude, 255 * -32768
        apply(3'd0, 64'h0000_0000_0000_00FF, 64'h0000_0000_0000_8000);
        check("R1", 64'h0000_0000_0000_8080);

        // R8: upper halves of the operands have no effect
        apply(3'd1, 64'h0000_0000_1122_3344, 64'h0000_0000_0234_0000);
        prev = res;
        apply(3'd1, 64'hDEAD_BEEF_1122_3344, 64'hCAFE_F00D_0234_0000);
        check("R8", prev);
        apply(3'd5, 64'h0000_0000_7788_99AA, 64'h0000_0000_8001_7FFF);
        prev = res;
        apply(3'd5, 64'hFFFF_FFFF_7788_99AA, 64'h1357_9BDF_8001_7FFF);
        check("R8", prev);
        apply(3'd0, 64'h0000_0000_5566_7788, 64'h1234_5678_9ABC_DEF0);
        prev = res;
        apply(3'd0, 64'hA5A5_5A5A_5566_7788, 64'h1234_5678_9ABC_DEF0);
        check("R8", prev);

        // Random sweep over all modes against the arithmetic model (R1)
        for (int k = 0; k < 400; k++) begin
            logic [2:0] m;
            m  = 3'(k % 8);
            a2 = {$urandom(), $urandom()};
            b2 = {$urandom(), $urandom()};
            apply(m, a2, b2);
            check((m == 3'd7) ? "R7" : "R1", ref_model(m, a2, b2));
        end

        // R9: asynchronous reset clears the output mid-run
        apply(3'd0, 64'h0000_0000_0403_0201, 64'h0100_0100_0100_0100);
        rst_n = 1'b0;
        #5;
        check("R9", 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        finish_run();
    end

endmodule